// File: doc/BRIEF.md
# Emulator Break and Monitor Controller

This block sits beside a small CPU inside an in-circuit emulator. It watches the CPU bus and the stack moves, and it decides when emulation has to stop. Seven sources can stop emulation: a host command, a set of programmable address comparators, instruction fetches beyond the program memory size, data accesses that land in no mapped region, writes into a read-only window, stack moves that leave the stack window, and the falling edge of an external break pin. All seven sources feed one registered break flag. A sticky cause vector records which sources fired. The host reads that vector and clears it.

The CPU runs four-phase bus cycles, T1 to T4, and the phase advances on every clock. The block samples the address and access kind in T2 and evaluates every bus-related condition at that point. It drives two active-low monitor lines. The first is a trace-trigger pulse that lasts exactly the T3 clock of a matching cycle. The second is a stop line that is low while the CPU is halted, while it sleeps, or while a break is in effect. The host sets the region limits and the comparators through a small indexed register file. Every window includes its lower bound and excludes its upper bound. All registers reset to zero, so the host has to program the map before it starts the CPU.

Top module: `emu_break_ctrl`

## Requirements
- R1: A one-clock `host_force` pulse sets `brk_req` on the next clock edge and sets cause bit 0. This also works while `cpu_halt` or `cpu_sleep` is high.
- R2: A fetch (`bus_kind`=0) whose address is at or above the ROM size register sets `brk_req` and cause bit 2.
- R3: A read (`bus_kind`=1) or write (`bus_kind`=2) whose address lies outside both the RAM window and the I/O window sets `brk_req` and cause bit 3.
- R4: A write inside the read-only window sets `brk_req` and cause bit 4, and `mem_we` stays low for that cycle. For any other write, `mem_we` is high during the T3 clock (`bus_phase`=2).
- R5: A `stk_push` or `stk_pop` strobe whose `sp_next` lies outside the stack window sets `brk_req` and cause bit 5 on the next edge.
- R6: A falling edge on `ext_brk_n` sets `brk_req` and cause bit 6 on the third rising clock edge after the fall. A rising edge does not start a break, and neither does a pin that stays low.
- R7: When the trace comparator matches a cycle, `trg_n` is low for exactly the T3 clock of that cycle. At all other times `trg_n` is high.
- R8: `stop_n` is low while `cpu_halt`, `cpu_sleep` or `brk_req` is high, and high otherwise.
- R9: Each breakpoint comparator fires when the address equals its address register and the access kind is enabled in its mode register. Mode bit 0 enables fetch, bit 1 enables read, bit 2 enables write. A firing comparator sets cause bit 1.
- R10: Bus-derived breaks appear in the T3 clock, one edge after the T2 sample. `brk_req` stays high until `host_resume`, and it is low on the edge after `host_resume`.
- R11: Cause bits are sticky and survive a resume. `host_ack` clears them. While `brk_req` is high, and during a resume cycle, no source sets a new cause bit or a new break.
- R12: Every window test is inclusive of the lower bound and exclusive of the upper bound.
- R13: During reset and right after it, `brk_req`=0, `brk_cause`=0, `trg_n`=1, `mem_we`=0 and `stop_n`=1. All configuration registers reset to zero.
- R14: A `cfg_wr` writes `cfg_wdata` into the register selected by `cfg_idx`:
  - 0: ROM size
  - 1 and 2: RAM base and limit
  - 3 and 4: I/O base and limit
  - 5 and 6: read-only base and limit
  - 7 and 8: stack base and limit
  - 9+2k: address of comparator k
  - 10+2k: mode of comparator k
  - The last comparator, k = BP_N, is the trace trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_idx | input | IW | Configuration register index |
| cfg_wdata | input | AW | Configuration write data |
| host_force | input | 1 | Host forced-break request |
| host_resume | input | 1 | Host resume command; drops the break |
| host_ack | input | 1 | Host clears the cause vector |
| bus_valid | input | 1 | A bus cycle is in progress |
| bus_phase | input | 2 | Bus phase, 0..3 = T1..T4 |
| bus_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 none |
| bus_addr | input | AW | Bus address |
| stk_push | input | 1 | Stack push strobe |
| stk_pop | input | 1 | Stack pop strobe |
| sp_next | input | AW | Stack pointer value after the move |
| cpu_halt | input | 1 | CPU halted |
| cpu_sleep | input | 1 | CPU sleeping |
| ext_brk_n | input | 1 | Asynchronous external break pin, falling edge active |
| brk_req | output | 1 | Break in effect |
| brk_cause | output | 7 | Sticky cause vector, bit per source |
| mem_we | output | 1 | Gated memory write enable |
| trg_n | output | 1 | Active-low trace-trigger pulse |
| stop_n | output | 1 | Active-low stop indicator |

## Verification
Bus-derived breaks and the trigger pulse come from a register loaded at the end of T2, so they are first visible in the T3 clock. `mem_we` is combinational and is valid within T3 itself. Host strobes and stack strobes take effect one edge later. The pin path takes three edges: two synchroniser stages and the break register. The bench changes inputs on falling edges and reads outputs 1 ns after a falling edge, counted from the stimulus by exactly these latencies. It also confirms that the trigger is back high in the clock after T3 and that the pin has not yet broken after two edges.

// File: rtl/brk_pkg.sv
// Package brk_pkg
// Purpose : shared encodings for the emulator break controller.
// Assumes : four bus phases, one per clock; seven break sources.
package brk_pkg;

    localparam logic [1:0] KIND_FETCH = 2'd0;
    localparam logic [1:0] KIND_READ  = 2'd1;
    localparam logic [1:0] KIND_WRITE = 2'd2;
    localparam logic [1:0] KIND_NONE  = 2'd3;

    localparam logic [1:0] PH_T1 = 2'd0;
    localparam logic [1:0] PH_T2 = 2'd1;
    localparam logic [1:0] PH_T3 = 2'd2;
    localparam logic [1:0] PH_T4 = 2'd3;

    localparam int CZ_FORCE = 0;
    localparam int CZ_BPT   = 1;
    localparam int CZ_ROM   = 2;
    localparam int CZ_UNMAP = 3;
    localparam int CZ_RO    = 4;
    localparam int CZ_STACK = 5;
    localparam int CZ_PIN   = 6;
    localparam int CAUSE_W  = 7;

    // configuration register indices
    localparam int IX_ROM_LIM  = 0;
    localparam int IX_RAM_BASE = 1;
    localparam int IX_RAM_LIM  = 2;
    localparam int IX_IO_BASE  = 3;
    localparam int IX_IO_LIM   = 4;
    localparam int IX_RO_BASE  = 5;
    localparam int IX_RO_LIM   = 6;
    localparam int IX_STK_BASE = 7;
    localparam int IX_STK_LIM  = 8;
    localparam int IX_CMP0     = 9;

endpackage

// File: rtl/brk_cfg_regs.sv
// Module brk_cfg_regs
// Purpose : host-writable register file for the region limits and the
//           comparator settings.
// Assumes : indices at or above NREG are ignored; reset clears every entry.
module brk_cfg_regs #(
    parameter int AW   = 12,
    parameter int NREG = 15,
    parameter int IW   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic [IW-1:0]            idx,
    input  logic [AW-1:0]            wdata,
    output logic [NREG-1:0][AW-1:0]  regs_q
);

    // one register per generated slot, written when selected
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // load slot g on a matching write
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[g] <= '0;
            else if (wr && (idx == IW'(g)))
                regs_q[g] <= wdata;
        end
    end

endmodule

// File: rtl/brk_addr_cmp.sv
// Module brk_addr_cmp
// Purpose : one address comparator qualified by the access kind.
// Assumes : mode bits [2:0] enable fetch, read and write; the upper bits
//           carry no meaning.
module brk_addr_cmp
    import brk_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          sample,
    input  logic [1:0]    kind,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] cmp_addr,
    input  logic [AW-1:0] mode_word,
    output logic          hit
);

    logic kind_en;
    logic unused_mode_hi;

    assign unused_mode_hi = ^mode_word[AW-1:3];

    // select the enable bit for the current access kind
    always_comb begin
        case (kind)
            KIND_FETCH: kind_en = mode_word[0];
            KIND_READ:  kind_en = mode_word[1];
            KIND_WRITE: kind_en = mode_word[2];
            default:    kind_en = 1'b0;
        endcase
    end

    assign hit = sample && kind_en && (addr == cmp_addr);

endmodule

// File: rtl/brk_region_check.sv
// Module brk_region_check
// Purpose : memory-map, write-protect and stack-window violation detection.
// Assumes : windows are [base, limit); the ROM window is [0, rom_lim).
module brk_region_check
    import brk_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          sample,
    input  logic [1:0]    kind,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] rom_lim,
    input  logic [AW-1:0] ram_base,
    input  logic [AW-1:0] ram_lim,
    input  logic [AW-1:0] io_base,
    input  logic [AW-1:0] io_lim,
    input  logic [AW-1:0] ro_base,
    input  logic [AW-1:0] ro_lim,
    input  logic [AW-1:0] stk_base,
    input  logic [AW-1:0] stk_lim,
    input  logic          stk_move,
    input  logic [AW-1:0] sp_next,
    output logic          ro_hit,
    output logic          rom_viol,
    output logic          unmap_viol,
    output logic          ro_viol,
    output logic          stk_viol
);

    function automatic logic in_win(input logic [AW-1:0] a,
                                    input logic [AW-1:0] lo,
                                    input logic [AW-1:0] hi);
        return (a >= lo) && (a < hi);
    endfunction

    logic is_data;
    logic is_write;
    logic in_ram;
    logic in_io;

    // classify the access and test each window
    always_comb begin
        is_data    = (kind == KIND_READ) || (kind == KIND_WRITE);
        is_write   = (kind == KIND_WRITE);
        in_ram     = in_win(addr, ram_base, ram_lim);
        in_io      = in_win(addr, io_base, io_lim);
        ro_hit     = is_write && in_win(addr, ro_base, ro_lim);
        rom_viol   = sample && (kind == KIND_FETCH) && (addr >= rom_lim);
        unmap_viol = sample && is_data && !in_ram && !in_io;
        ro_viol    = sample && ro_hit;
        stk_viol   = stk_move && !in_win(sp_next, stk_base, stk_lim);
    end

endmodule

// File: rtl/brk_pin_sync.sv
// Module brk_pin_sync
// Purpose : synchronise the external break pin and flag its falling edge.
// Assumes : the pin idles high; the edge flag is valid two edges after the fall.
module brk_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);

    logic [STAGES:0] sh_q;

    // shift the pin through the synchroniser and one history stage
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh_q <= '1;
        else
            sh_q <= {sh_q[STAGES-1:0], pin_n};
    end

    assign fall = sh_q[STAGES] && !sh_q[STAGES-1];

endmodule

// File: rtl/emu_break_ctrl.sv
// Module emu_break_ctrl
// Purpose : merge every break source into one registered break flag with
//           a sticky cause vector, and drive the trace-trigger and stop lines.
// Assumes : bus_phase advances one step per clock; bus address and kind are
//           stable from T2; the host programs the map before running.
module emu_break_ctrl
    import brk_pkg::*;
#(
    parameter  int AW   = 12,
    parameter  int BP_N = 2,
    localparam int NCMP = BP_N + 1,
    localparam int NREG = IX_CMP0 + 2 * NCMP,
    localparam int IW   = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [IW-1:0]      cfg_idx,
    input  logic [AW-1:0]      cfg_wdata,
    input  logic               host_force,
    input  logic               host_resume,
    input  logic               host_ack,
    input  logic               bus_valid,
    input  logic [1:0]         bus_phase,
    input  logic [1:0]         bus_kind,
    input  logic [AW-1:0]      bus_addr,
    input  logic               stk_push,
    input  logic               stk_pop,
    input  logic [AW-1:0]      sp_next,
    input  logic               cpu_halt,
    input  logic               cpu_sleep,
    input  logic               ext_brk_n,
    output logic               brk_req,
    output logic [CAUSE_W-1:0] brk_cause,
    output logic               mem_we,
    output logic               trg_n,
    output logic               stop_n
);

    logic [NREG-1:0][AW-1:0] cfg_q;
    logic [AW-1:0]           ro_base;
    logic [AW-1:0]           ro_lim;
    logic                    sample;
    logic [NCMP-1:0]         cmp_hit;
    logic                    ro_hit;
    logic                    rom_viol;
    logic                    unmap_viol;
    logic                    ro_viol;
    logic                    stk_viol;
    logic                    pin_fall;
    logic                    arm;
    logic [CAUSE_W-1:0]      src;
    logic [CAUSE_W-1:0]      new_cause;
    logic                    brk_q;
    logic [CAUSE_W-1:0]      cause_q;
    logic                    trg_q;

    assign sample  = bus_valid && (bus_phase == PH_T2);
    assign ro_base = cfg_q[IX_RO_BASE];
    assign ro_lim  = cfg_q[IX_RO_LIM];

    brk_cfg_regs #(.AW(AW), .NREG(NREG), .IW(IW)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cfg_wr),
        .idx    (cfg_idx),
        .wdata  (cfg_wdata),
        .regs_q (cfg_q)
    );

    // breakpoint comparators, the last one serves as the trace trigger
    for (genvar k = 0; k < NCMP; k++) begin : g_cmp
        brk_addr_cmp #(.AW(AW)) u_cmp (
            .sample    (sample),
            .kind      (bus_kind),
            .addr      (bus_addr),
            .cmp_addr  (cfg_q[IX_CMP0 + 2*k]),
            .mode_word (cfg_q[IX_CMP0 + 2*k + 1]),
            .hit       (cmp_hit[k])
        );
    end

    brk_region_check #(.AW(AW)) u_region (
        .sample     (sample),
        .kind       (bus_kind),
        .addr       (bus_addr),
        .rom_lim    (cfg_q[IX_ROM_LIM]),
        .ram_base   (cfg_q[IX_RAM_BASE]),
        .ram_lim    (cfg_q[IX_RAM_LIM]),
        .io_base    (cfg_q[IX_IO_BASE]),
        .io_lim     (cfg_q[IX_IO_LIM]),
        .ro_base    (ro_base),
        .ro_lim     (ro_lim),
        .stk_base   (cfg_q[IX_STK_BASE]),
        .stk_lim    (cfg_q[IX_STK_LIM]),
        .stk_move   (stk_push || stk_pop),
        .sp_next    (sp_next),
        .ro_hit     (ro_hit),
        .rom_viol   (rom_viol),
        .unmap_viol (unmap_viol),
        .ro_viol    (ro_viol),
        .stk_viol   (stk_viol)
    );

    brk_pin_sync #(.STAGES(2)) u_pin (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (ext_brk_n),
        .fall  (pin_fall)
    );

    // gather the sources; detection is masked during a break or a resume
    always_comb begin
        src            = '0;
        src[CZ_FORCE]  = host_force;
        src[CZ_BPT]    = |cmp_hit[NCMP-2:0];
        src[CZ_ROM]    = rom_viol;
        src[CZ_UNMAP]  = unmap_viol;
        src[CZ_RO]     = ro_viol;
        src[CZ_STACK]  = stk_viol;
        src[CZ_PIN]    = pin_fall;
        arm            = !brk_q && !host_resume;
        new_cause      = arm ? src : '0;
    end

    // break state: set by any armed source, dropped by resume
    always_ff @(posedge clk) begin
        if (!rst_n)
            brk_q <= 1'b0;
        else if (host_resume)
            brk_q <= 1'b0;
        else if (|new_cause)
            brk_q <= 1'b1;
    end

    // sticky cause vector, cleared by acknowledge, new bits win
    always_ff @(posedge clk) begin
        if (!rst_n)
            cause_q <= '0;
        else
            cause_q <= (host_ack ? '0 : cause_q) | new_cause;
    end

    // trace trigger registered at T2 so the low pulse covers T3
    always_ff @(posedge clk) begin
        if (!rst_n)
            trg_q <= 1'b0;
        else
            trg_q <= cmp_hit[NCMP-1];
    end

    assign brk_req   = brk_q;
    assign brk_cause = cause_q;
    assign trg_n     = !trg_q;
    assign mem_we    = bus_valid && (bus_phase == PH_T3) &&
                       (bus_kind == KIND_WRITE) && !ro_hit;
    assign stop_n    = !(cpu_halt || cpu_sleep || brk_q);

endmodule

// File: rtl/brk_ctrl_chk.sv
// Module brk_ctrl_chk
// Purpose : temporal checks on the break controller ports, bound to the top.
// Assumes : bus_phase advances one step per clock.
module brk_ctrl_chk
    import brk_pkg::*;
#(
    parameter int AW = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_valid,
    input logic [1:0]         bus_phase,
    input logic [AW-1:0]      bus_addr,
    input logic               cpu_halt,
    input logic               cpu_sleep,
    input logic               host_resume,
    input logic               host_ack,
    input logic               brk_req,
    input logic [CAUSE_W-1:0] brk_cause,
    input logic               mem_we,
    input logic               trg_n,
    input logic               stop_n,
    input logic [AW-1:0]      ro_base,
    input logic [AW-1:0]      ro_lim
);

    AST_STOP_ON_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_halt || cpu_sleep) |-> !stop_n); // R8
    AST_STOP_IN_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> !stop_n); // R8
    AST_TRG_AFTER_T2: assert property (@(posedge clk) disable iff (!rst_n)
        !trg_n |-> ($past(bus_valid) && $past(bus_phase) == PH_T2)); // R7
    AST_RESUME_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        host_resume |=> !brk_req); // R10
    AST_BREAK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req && !host_resume) |=> brk_req); // R10
    AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_req) |-> (brk_cause != '0)); // R10
    AST_CAUSE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req && !host_ack) |=> $stable(brk_cause)); // R11
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack && (brk_req || host_resume)) |=> (brk_cause == '0)); // R11
    AST_NO_PROTECTED_WE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !((bus_addr >= ro_base) && (bus_addr < ro_lim))); // R4

endmodule

bind emu_break_ctrl brk_ctrl_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_phase   (bus_phase),
    .bus_addr    (bus_addr),
    .cpu_halt    (cpu_halt),
    .cpu_sleep   (cpu_sleep),
    .host_resume (host_resume),
    .host_ack    (host_ack),
    .brk_req     (brk_req),
    .brk_cause   (brk_cause),
    .mem_we      (mem_we),
    .trg_n       (trg_n),
    .stop_n      (stop_n),
    .ro_base     (ro_base),
    .ro_lim      (ro_lim)
);

// File: tb/emu_break_ctrl_tb.sv
`timescale 1ns/1ps
module emu_break_ctrl_tb;

    localparam int AW = 12;
    localparam int IW = 4;
    localparam int NV = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          host_force = 1'b0;
    logic          host_resume = 1'b0;
    logic          host_ack = 1'b0;
    logic          bus_valid = 1'b0;
    logic [1:0]    bus_phase = 2'd0;
    logic [1:0]    bus_kind = 2'd3;
    logic [AW-1:0] bus_addr = '0;
    logic          stk_push = 1'b0;
    logic          stk_pop = 1'b0;
    logic [AW-1:0] sp_next = '0;
    logic          cpu_halt = 1'b0;
    logic          cpu_sleep = 1'b0;
    logic          ext_brk_n = 1'b1;
    logic          brk_req;
    logic [6:0]    brk_cause;
    logic          mem_we;
    logic          trg_n;
    logic          stop_n;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    emu_break_ctrl #(.AW(AW), .BP_N(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .host_force(host_force),
        .host_resume(host_resume), .host_ack(host_ack),
        .bus_valid(bus_valid), .bus_phase(bus_phase), .bus_kind(bus_kind),
        .bus_addr(bus_addr), .stk_push(stk_push), .stk_pop(stk_pop),
        .sp_next(sp_next), .cpu_halt(cpu_halt), .cpu_sleep(cpu_sleep),
        .ext_brk_n(ext_brk_n), .brk_req(brk_req), .brk_cause(brk_cause),
        .mem_we(mem_we), .trg_n(trg_n), .stop_n(stop_n)
    );

    // {kind, addr, exp_cause, exp_brk, exp_we, exp_trg}
    localparam logic [23:0] VEC [NV] = '{
        {2'd0, 12'h3FF, 7'h00, 1'b0, 1'b0, 1'b1},
        {2'd0, 12'h400, 7'h04, 1'b1, 1'b0, 1'b1},
        {2'd0, 12'h123, 7'h02, 1'b1, 1'b0, 1'b1},
        {2'd1, 12'h123, 7'h08, 1'b1, 1'b0, 1'b1},
        {2'd1, 12'h0FF, 7'h00, 1'b0, 1'b0, 1'b1},
        {2'd1, 12'h100, 7'h08, 1'b1, 1'b0, 1'b1},
        {2'd1, 12'hF00, 7'h00, 1'b0, 1'b0, 1'b1},
        {2'd1, 12'hF80, 7'h08, 1'b1, 1'b0, 1'b1},
        {2'd2, 12'h07F, 7'h00, 1'b0, 1'b1, 1'b1},
        {2'd2, 12'h080, 7'h10, 1'b1, 1'b0, 1'b1},
        {2'd2, 12'h010, 7'h02, 1'b1, 1'b1, 1'b1},
        {2'd1, 12'h010, 7'h00, 1'b0, 1'b0, 1'b1},
        {2'd1, 12'h020, 7'h00, 1'b0, 1'b0, 1'b0},
        {2'd2, 12'h020, 7'h00, 1'b0, 1'b1, 1'b1},
        {2'd2, 12'h100, 7'h08, 1'b1, 1'b1, 1'b1},
        {2'd2, 12'hFFF, 7'h08, 1'b1, 1'b1, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wcfg(input int i, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = IW'(i); cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic clear_brk();
        @(negedge clk);
        host_resume = 1'b1; host_ack = 1'b1;
        @(negedge clk);
        host_resume = 1'b0; host_ack = 1'b0;
    endtask

    // run T1..T4, return outputs seen in T3, then leave the bus idle
    task automatic bus_cycle(input logic [1:0] k, input logic [AW-1:0] a,
                             output logic b, output logic [6:0] c,
                             output logic we, output logic tr);
        @(negedge clk); bus_valid = 1'b1; bus_kind = k; bus_addr = a; bus_phase = 2'd0;
        @(negedge clk); bus_phase = 2'd1;
        @(negedge clk); bus_phase = 2'd2;
        #1; b = brk_req; c = brk_cause; we = mem_we; tr = trg_n;
        @(negedge clk); bus_phase = 2'd3;
        @(negedge clk); bus_valid = 1'b0; bus_kind = 2'd3; bus_phase = 2'd0;
    endtask

    task automatic stack_move(input logic push, input logic [AW-1:0] sp);
        @(negedge clk); stk_push = push; stk_pop = !push; sp_next = sp;
        @(negedge clk); stk_push = 1'b0; stk_pop = 1'b0;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic b, we, tr;
        logic [6:0] c;

        repeat (3) @(negedge clk);
        #1;
        chk("R13 brk_req in reset", 32'(brk_req), 0);
        chk("R13 cause in reset",   32'(brk_cause), 0);
        chk("R13 trg_n in reset",   32'(trg_n), 1);
        chk("R13 stop_n in reset",  32'(stop_n), 1);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk("R13 idle after reset", 32'({brk_req, brk_cause, mem_we, trg_n, stop_n}), 32'b0_0000000_0_1_1);

        // R14 program the map
        wcfg(0, 12'h400);
        wcfg(1, 12'h000); wcfg(2, 12'h100);
        wcfg(3, 12'hF00); wcfg(4, 12'hF80);
        wcfg(5, 12'h080); wcfg(6, 12'h100);
        wcfg(7, 12'h040); wcfg(8, 12'h080);
        wcfg(9, 12'h123);  wcfg(10, 12'h001);
        wcfg(11, 12'h010); wcfg(12, 12'h004);
        wcfg(13, 12'h020); wcfg(14, 12'h002);

        // table walk: R2 R3 R4 R7 R9 R10 R12
        for (int v = 0; v < NV; v++) begin
            bus_cycle(VEC[v][23:22], VEC[v][21:10], b, c, we, tr);
            chk($sformatf("R2 R3 R4 R7 R9 R10 R12 vector %0d", v),
                32'({b, c, we, tr}),
                32'({VEC[v][2], VEC[v][9:3], VEC[v][1], VEC[v][0]}));
            #1;
            if (v == 12) chk("R7 trigger back high after T3", 32'(trg_n), 1);
            clear_brk();
        end

        // R1 forced break while halted, R8 stop line
        @(negedge clk); cpu_halt = 1'b1;
        #1; chk("R8 stop_n low on halt", 32'(stop_n), 0);
        @(negedge clk); host_force = 1'b1;
        @(negedge clk); host_force = 1'b0;
        #1; chk("R1 force under halt", 32'({brk_req, brk_cause}), 32'({1'b1, 7'h01}));
        @(negedge clk); cpu_halt = 1'b0;
        #1; chk("R8 stop_n low during break", 32'(stop_n), 0);

        // R11 masking while in break, sticky across resume
        bus_cycle(2'd0, 12'h400, b, c, we, tr);
        chk("R11 masked source", 32'({b, c}), 32'({1'b1, 7'h01}));
        @(negedge clk); host_resume = 1'b1;
        @(negedge clk); host_resume = 1'b0;
        #1; chk("R10 resume drops break", 32'({brk_req, brk_cause, stop_n}), 32'({1'b0, 7'h01, 1'b1}));
        @(negedge clk); host_ack = 1'b1;
        @(negedge clk); host_ack = 1'b0;
        #1; chk("R11 ack clears cause", 32'(brk_cause), 0);

        @(negedge clk); cpu_sleep = 1'b1;
        #1; chk("R8 stop_n low on sleep", 32'(stop_n), 0);
        @(negedge clk); cpu_sleep = 1'b0;
        #1; chk("R8 stop_n high when running", 32'(stop_n), 1);

        // R5 stack window with R12 bounds
        stack_move(1'b1, 12'h040);
        chk("R5 push at base", 32'(brk_req), 0);
        stack_move(1'b1, 12'h07F);
        chk("R5 push below limit", 32'(brk_req), 0);
        stack_move(1'b1, 12'h080);
        chk("R5 push at limit", 32'({brk_req, brk_cause}), 32'({1'b1, 7'h20}));
        clear_brk();
        stack_move(1'b0, 12'h03F);
        chk("R5 pop under base", 32'({brk_req, brk_cause}), 32'({1'b1, 7'h20}));
        clear_brk();

        // R6 pin falling edge, three edges
        @(negedge clk); ext_brk_n = 1'b0;
        @(negedge clk); @(negedge clk);
        #1; chk("R6 no break after two edges", 32'(brk_req), 0);
        @(negedge clk);
        #1; chk("R6 break on third edge", 32'({brk_req, brk_cause}), 32'({1'b1, 7'h40}));
        clear_brk();
        repeat (4) @(negedge clk);
        #1; chk("R6 steady low no break", 32'({brk_req, brk_cause}), 0);
        ext_brk_n = 1'b1;
        repeat (4) @(negedge clk);
        #1; chk("R6 rising edge no break", 32'({brk_req, brk_cause}), 0);

        // R14 reprogram ROM size, R12 at the new bound
        wcfg(0, 12'h200);
        bus_cycle(2'd0, 12'h1FF, b, c, we, tr);
        chk("R14 fetch below new ROM size", 32'(b), 0);
        bus_cycle(2'd0, 12'h200, b, c, we, tr);
        chk("R14 fetch at new ROM size", 32'({b, c}), 32'({1'b1, 7'h04}));
        clear_brk();

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule